// File: doc/BRIEF.md
# Eight-Bit Event Timer with Assignable Down-Count Prescaler

This block is an 8-bit up counter. It advances on one of two kinds of event. The first is the instruction-cycle enable. The second is a chosen transition on an external timer pin, which passes through a two-flop synchronizer before the edge is detected.

A down-counting prescaler can sit between the event source and the counter. Its ratio can be set from 1:2 to 1:256 in powers of two. One control bit assigns the prescaler away from the timer, to the watchdog. In that case the timer counts every event at 1:1 and the prescaler holds its value.

Software can load the counter through a write port, and that write also empties the prescaler. Both the counter and the prescaler can be read at any time. When the counter wraps past its top value it sets a sticky overflow flag, and the flag stays set until software clears it.

Top module: `tmr8_pscl`

## Requirements
- R1: After synchronous reset the counter reads 0x00, the prescaler reads 0x00 and the overflow flag is low. The control register resets to the prescaler-bypassed setting: control bit 3 = 1, all other control bits 0.
- R2: With control bit 5 (source) = 0 and the prescaler bypassed, the counter rises by exactly one at each clock edge that samples `cyc_tick` high. It does not change when `cyc_tick` is low.
- R3: With the source bit = 1 and control bit 4 (edge) = 0, the counter counts low-to-high transitions of `tmr_pin`. Each count appears at the third clock edge after the pin changes. High-to-low transitions are not counted.
- R4: With the source bit = 1 and the edge bit = 1, only high-to-low transitions of `tmr_pin` are counted, with the same three-edge latency.
- R5: With control bit 3 = 0 (prescaler drives the timer) and ratio field bits [2:0] = r, the counter rises once per 2^(r+1) selected events. The first rise comes on the 2^(r+1)-th event after the prescaler was cleared.
- R6: The prescaler is a down counter. After n events since it was cleared, it reads (0 - n) mod 256, updated at the same edge as each event.
- R7: A counter write loads `cnt_wdata` at the next edge and clears the prescaler to 0x00. If an increment falls in the same cycle, the write wins.
- R8: While control bit 3 = 1, events leave the prescaler value unchanged.
- R9: An increment from 0xFF to 0x00 sets `ovf_irq` at the same edge. The flag stays high until `ovf_clr` is sampled high. If a new overflow and a clear coincide, the flag stays set.
- R10: A counter write never sets the overflow flag, even a write of 0x00 while the counter holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle enable, one clock wide |
| tmr_pin | input | 1 | Asynchronous external timer pin |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control value: [5] source, [4] edge, [3] bypass prescaler, [2:0] ratio |
| cnt_we | input | 1 | Counter write strobe (also clears prescaler) |
| cnt_wdata | input | 8 | Counter load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_rdata | output | 8 | Current counter value |
| psc_rdata | output | 8 | Current prescaler value |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
The following results are due one clock edge after their stimulus is sampled:
- counter increments from `cyc_tick`;
- prescaler decrements;
- register loads;
- the overflow flag.

Pin events land three edges after the pin is driven: two synchronizer stages, then the counter register. The bench drives every input on a falling clock edge and compares outputs on the next falling edge. For pin stimulus it waits exactly three falling edges before comparing. Expected counter and prescaler values are recomputed arithmetically from the running event count, for all eight prescale ratios.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 8;
    localparam int PSC_W = 8;
    localparam int SEL_W = 3;
    localparam int CTL_W = SEL_W + 3;

    typedef struct packed {
        logic             src_pin;
        logic             edge_fall;
        logic             psc_wdt;
        logic [SEL_W-1:0] ratio;
    } tmr_ctl_t;

    localparam tmr_ctl_t CTL_RST = '{src_pin: 1'b0, edge_fall: 1'b0,
                                     psc_wdt: 1'b1, ratio: '0};

    // low (ratio+1) bits set: division by 2**(ratio+1)
    function automatic logic [PSC_W-1:0] ratio_mask(input logic [SEL_W-1:0] r);
        logic [PSC_W-1:0] m;
        for (int i = 0; i < PSC_W; i++) begin
            m[i] = (i <= int'(r));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic sel_fall,
    output logic evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= cur;
        end
    end

    assign evt = sel_fall ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler import tmr_pkg::*; #(
    parameter int W  = PSC_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          evt_en,
    input  logic [SW-1:0] ratio,
    output logic [W-1:0]  psc_q,
    output logic          tick
);
    logic [W-1:0] psc_next;
    logic [W-1:0] mask;

    assign mask     = W'(ratio_mask(SEL_W'(ratio)));
    assign psc_next = psc_q - 1'b1;
    assign tick     = evt_en && ((psc_next & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            psc_q <= '0;
        end else if (evt_en) begin
            psc_q <= psc_next;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt_q,
    output logic         ovf_q
);
    logic wrap;

    assign wrap = inc && !we && (cnt_q == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (we) begin
                cnt_q <= wdata;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr8_pscl.sv
module tmr8_pscl import tmr_pkg::*; #(
    parameter int CW   = CNT_W,
    parameter int PW   = PSC_W,
    parameter int SYNC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_tick,
    input  logic             tmr_pin,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_we,
    input  logic [CW-1:0]    cnt_wdata,
    input  logic             ovf_clr,
    output logic [CW-1:0]    cnt_rdata,
    output logic [PW-1:0]    psc_rdata,
    output logic             ovf_irq
);
    tmr_ctl_t ctl_q;
    logic     pin_evt;
    logic     src_evt;
    logic     psc_bypass;
    logic     psc_tick;
    logic     cnt_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RST;
        end else if (ctl_we) begin
            ctl_q <= tmr_ctl_t'(ctl_wdata);
        end
    end

    assign psc_bypass = ctl_q.psc_wdt;

    tmr_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (tmr_pin),
        .sel_fall (ctl_q.edge_fall),
        .evt      (pin_evt)
    );

    assign src_evt = ctl_q.src_pin ? pin_evt : cyc_tick;

    tmr_prescaler #(.W(PW), .SW(SEL_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_we),
        .evt_en (src_evt && !psc_bypass),
        .ratio  (ctl_q.ratio),
        .psc_q  (psc_rdata),
        .tick   (psc_tick)
    );

    assign cnt_inc = psc_bypass ? src_evt : psc_tick;

    tmr_counter #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .we      (cnt_we),
        .wdata   (cnt_wdata),
        .inc     (cnt_inc),
        .ovf_clr (ovf_clr),
        .cnt_q   (cnt_rdata),
        .ovf_q   (ovf_irq)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CW = 8,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_we,
    input logic [CW-1:0] cnt_wdata,
    input logic          ovf_clr,
    input logic [CW-1:0] cnt_rdata,
    input logic [PW-1:0] psc_rdata,
    input logic          ovf_irq,
    input logic          psc_bypass
);
    // R1
    a_r1_reset_vals: assert property (@(posedge clk)
        $past(rst) |-> (cnt_rdata == '0 && psc_rdata == '0 && !ovf_irq));

    // R2
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (cnt_rdata == $past(cnt_rdata) ||
                     cnt_rdata == $past(cnt_rdata) + 1'b1));

    // R7
    a_r7_write_load: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_rdata == $past(cnt_wdata) && psc_rdata == '0));

    // R8
    a_r8_psc_hold: assert property (@(posedge clk) disable iff (rst)
        (psc_bypass && !cnt_we) |=> $stable(psc_rdata));

    // R9
    a_r9_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && cnt_rdata == {CW{1'b1}}) |=>
            (cnt_rdata == {CW{1'b1}} || ovf_irq));

    // R9
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq && !ovf_clr) |=> ovf_irq);

    // R10
    a_r10_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_irq) |-> ($past(cnt_rdata) == {CW{1'b1}} && !$past(cnt_we)
                            && cnt_rdata == '0));
endmodule

bind tmr8_pscl tmr_chk #(.CW(CW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .ovf_clr    (ovf_clr),
    .cnt_rdata  (cnt_rdata),
    .psc_rdata  (psc_rdata),
    .ovf_irq    (ovf_irq),
    .psc_bypass (psc_bypass)
);

// File: tb/sim_tmr8_pscl.sv
module sim_tmr8_pscl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_tick = 1'b0;
    logic       tmr_pin = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ovf_clr = 1'b0;
    logic [7:0] cnt_rdata;
    logic [7:0] psc_rdata;
    logic       ovf_irq;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_pscl u0 (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .tmr_pin(tmr_pin),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .cnt_rdata(cnt_rdata),
        .psc_rdata(psc_rdata), .ovf_irq(ovf_irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles", WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic src, input logic fall, input logic byp,
                           input logic [2:0] r);
        ctl_we = 1'b1;
        ctl_wdata = {src, fall, byp, r};
        step();
        ctl_we = 1'b0;
    endtask

    task automatic load_cnt(input logic [7:0] v);
        cnt_we = 1'b1;
        cnt_wdata = v;
        step();
        cnt_we = 1'b0;
    endtask

    task automatic pin_to(input logic v);
        tmr_pin = v;
        step(); step(); step();
    endtask

    initial begin
        int ev;
        logic [7:0] exp_cnt;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 cnt", cnt_rdata, 8'h00);
        chk("R1 psc", psc_rdata, 8'h00);
        chk("R1 ovf", {7'd0, ovf_irq}, 8'h00);

        // R2 cycle ticks, bypassed prescaler (reset default); R8 prescaler holds
        exp_cnt = 8'h00;
        for (int k = 0; k < 30; k++) begin
            cyc_tick = (k % 3 != 0);
            step();
            if (cyc_tick) exp_cnt++;
            chk("R2 cnt", cnt_rdata, exp_cnt);
            chk("R8 psc hold", psc_rdata, 8'h00);
        end
        cyc_tick = 1'b0;

        // R5/R6 sweep over every ratio
        for (int r = 0; r < 8; r++) begin
            int div;
            div = 1 << (r + 1);
            set_ctl(1'b0, 1'b0, 1'b0, 3'(r));
            load_cnt(8'h00);
            chk("R7 psc cleared", psc_rdata, 8'h00);
            ev = 0;
            for (int k = 0; k < 2 * div + 6; k++) begin
                cyc_tick = (k % 4 != 3);
                step();
                if (cyc_tick) ev++;
                chk("R5 cnt", cnt_rdata, 8'(ev / div));
                chk("R6 psc", psc_rdata, 8'(-ev));
            end
            cyc_tick = 1'b0;
        end

        // R7 write mid-count, with a tick in the same cycle
        set_ctl(1'b0, 1'b0, 1'b0, 3'd2);
        load_cnt(8'h10);
        repeat (3) begin cyc_tick = 1'b1; step(); end
        chk("R6 psc mid", psc_rdata, 8'hFD);
        cnt_we = 1'b1; cnt_wdata = 8'h5A; cyc_tick = 1'b1;
        step();
        cnt_we = 1'b0; cyc_tick = 1'b0;
        chk("R7 cnt load", cnt_rdata, 8'h5A);
        chk("R7 psc clr", psc_rdata, 8'h00);

        // R8 bypass: prescaler value frozen while events arrive
        repeat (5) begin cyc_tick = 1'b1; step(); end
        cyc_tick = 1'b0;
        chk("R6 psc after 5", psc_rdata, 8'hFB);
        set_ctl(1'b0, 1'b0, 1'b1, 3'd2);
        exp_cnt = cnt_rdata;
        for (int k = 0; k < 6; k++) begin
            cyc_tick = 1'b1;
            step();
            exp_cnt++;
            chk("R8 cnt 1:1", cnt_rdata, exp_cnt);
            chk("R8 psc frozen", psc_rdata, 8'hFB);
        end
        cyc_tick = 1'b0;

        // R3 rising pin edges
        set_ctl(1'b1, 1'b0, 1'b1, 3'd0);
        load_cnt(8'h00);
        for (int k = 1; k <= 5; k++) begin
            pin_to(1'b1);
            chk("R3 rise counted", cnt_rdata, 8'(k));
            pin_to(1'b0);
            chk("R3 fall ignored", cnt_rdata, 8'(k));
        end
        // R3 cyc_tick ignored in pin mode
        cyc_tick = 1'b1; step(); step(); cyc_tick = 1'b0; step();
        chk("R3 tick ignored", cnt_rdata, 8'd5);

        // R4 falling pin edges
        set_ctl(1'b1, 1'b1, 1'b1, 3'd0);
        load_cnt(8'h00);
        for (int k = 1; k <= 5; k++) begin
            pin_to(1'b1);
            chk("R4 rise ignored", cnt_rdata, 8'(k - 1));
            pin_to(1'b0);
            chk("R4 fall counted", cnt_rdata, 8'(k));
        end

        // R5 with pin source through prescaler 1:2
        set_ctl(1'b1, 1'b0, 1'b0, 3'd0);
        load_cnt(8'h00);
        pin_to(1'b1); pin_to(1'b0);
        chk("R5 pin first", cnt_rdata, 8'd0);
        chk("R6 pin psc", psc_rdata, 8'hFF);
        pin_to(1'b1); pin_to(1'b0);
        chk("R5 pin second", cnt_rdata, 8'd1);

        // R9 overflow
        set_ctl(1'b0, 1'b0, 1'b1, 3'd0);
        load_cnt(8'hFD);
        for (int k = 0; k < 2; k++) begin
            cyc_tick = 1'b1; step();
            chk("R9 no early ovf", {7'd0, ovf_irq}, 8'h00);
        end
        step();
        chk("R9 wrap cnt", cnt_rdata, 8'h00);
        chk("R9 ovf set", {7'd0, ovf_irq}, 8'h01);
        step(); step();
        cyc_tick = 1'b0;
        chk("R9 ovf sticky", {7'd0, ovf_irq}, 8'h01);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk("R9 ovf cleared", {7'd0, ovf_irq}, 8'h00);
        load_cnt(8'hFF);
        cyc_tick = 1'b1; ovf_clr = 1'b1; step();
        cyc_tick = 1'b0; ovf_clr = 1'b0;
        chk("R9 set beats clear", {7'd0, ovf_irq}, 8'h01);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;

        // R10 write never overflows
        load_cnt(8'hFF);
        cnt_we = 1'b1; cnt_wdata = 8'h00; cyc_tick = 1'b1; step();
        cnt_we = 1'b0; cyc_tick = 1'b0;
        chk("R10 cnt", cnt_rdata, 8'h00);
        chk("R10 no ovf", {7'd0, ovf_irq}, 8'h00);
        step();
        chk("R10 still no ovf", {7'd0, ovf_irq}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule